// File: doc/BRIEF.md
# Oversampling UART Receiver with Address Filtering

This block receives asynchronous serial frames on a single data line. It is the receive half of a microcontroller-style serial port. A one-cycle enable pulse at sixteen times the bit rate times the receiver. The receiver looks for a start edge while it is idle and rejects start bits that do not hold low. It settles each bit by a two-of-three vote taken near the centre of the bit. A frame has eight data bits and then one stop bit, or, in the nine-bit modes, eight data bits, a ninth bit and then the stop bit. Data bits arrive least significant bit first.

A completed frame is stored in a data buffer and an extra-bit register, and a sticky receive flag is raised. This happens only when the flag is already clear and the address-filter rule allows the frame. With the filter on, a frame is kept only if its extra bit is 1, so that address bytes can be told apart from data bytes on a shared line. A separate sticky framing-error flag records a stop bit that was read as 0. Through a selector, this flag can share one read-back bit position with the upper mode bit.

Top module: `uart_rx_mpf`

## Requirements
- R1: While `rx_en` is 0, or `mode` (upper bit = SM0, lower bit = SM1) is 2'b00, the receiver stays idle and no frame changes `rx_flag`, `rx_data` or `rx_bit9`.
- R2: A 1-to-0 transition on the synchronised line, seen at any clock, restarts the 16-state tick counter at 0. The bit samples are taken at counter states 7, 8 and 9 of each bit time, so reception works whatever the start edge's phase relative to `tick16`.
- R3: Each bit value is the majority of its three samples. A disturbance that covers only one of the three samples does not change the received data.
- R4: If the voted start bit is 1, the receiver drops the frame and returns to hunting for a falling edge. The outputs do not change.
- R5: A frame is accepted only if `rx_flag` is 0 at its end. A frame that ends while `rx_flag` is 1 is discarded, and `rx_data` and `rx_bit9` keep their values.
- R6: With `addr_filt` = 1, a frame is accepted only if its extra bit is 1. The extra bit is the ninth bit in modes 2'b10 and 2'b11 and the stop bit in mode 2'b01. With `addr_filt` = 0, the extra bit has no effect on acceptance.
- R7: On acceptance, `rx_data` holds the eight data bits, the first received bit in bit 0. `rx_bit9` holds the stop bit in mode 2'b01 and the ninth bit in the nine-bit modes.
- R8: `rx_flag` rises at the vote of the stop bit, in the stop bit's 10th tick. It stays 1 until a `flag_clr` pulse.
- R9: `fe` is set whenever a frame's voted stop bit is 0, whether or not the frame is accepted. It stays 1 until a `fe_clr` pulse.
- R10: `ctl_bit7` shows `fe` when `fe_alias_sel` = 1 and `mode[1]` when `fe_alias_sel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_en | input | 1 | Receive enable |
| mode | input | 2 | Frame mode {SM0, SM1}: 01 eight-bit, 10/11 nine-bit, 00 off |
| addr_filt | input | 1 | Address filter: keep only frames whose extra bit is 1 |
| fe_alias_sel | input | 1 | Selects the framing-error flag onto `ctl_bit7` |
| flag_clr | input | 1 | Pulse that clears `rx_flag` |
| fe_clr | input | 1 | Pulse that clears the framing-error flag |
| rx_data | output | 8 | Received data buffer |
| rx_bit9 | output | 1 | Received extra bit (stop bit or ninth bit) |
| rx_flag | output | 1 | Sticky receive-complete flag |
| ctl_bit7 | output | 1 | Shared read-back bit: framing error or `mode[1]` |

## Verification
A misaligned tick counter or a wrong sample point makes bits slip. This shows as a wrong `rx_data` value on the first frame that starts off the tick grid, or on the first frame that has a one-tick disturbance. A sequencer that does not go back to idle after a false start, or that counts the wrong number of bits for the mode, either loses the next frame or raises `rx_flag` at the wrong time. That shows within one frame, checked both before and after the stop-bit vote. Broken acceptance gating appears as a changed `rx_data` or a wrong `rx_flag` right after a frame that should have been dropped.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef enum logic {
    RX_IDLE   = 1'b0,
    RX_ACTIVE = 1'b1
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/urx_sampler.sv
module urx_sampler #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4,
  parameter int S_FIRST     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  output logic             rxd_s,
  output logic             fall,
  output logic             vote
);
  localparam logic [CNT_W-1:0] PT_A = CNT_W'(S_FIRST);
  localparam logic [CNT_W-1:0] PT_B = CNT_W'(S_FIRST + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   smp_a_q, smp_b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_a_q <= 1'b1;
      smp_b_q <= 1'b1;
    end else begin
      if (tick && cnt == PT_A) smp_a_q <= sync_q[SYNC_STAGES-1];
      if (tick && cnt == PT_B) smp_b_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rxd_s = sync_q[SYNC_STAGES-1];
  assign fall  = prev_q & ~rxd_s;
  assign vote  = urx_pkg::maj3(smp_a_q, smp_b_q, rxd_s);
endmodule

// File: rtl/urx_framer.sv
module urx_framer #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fall,
  input  logic              vote,
  input  logic              enable,
  input  logic              nine_bit,
  output logic [CNT_W-1:0]  cnt,
  output logic              frame_done,
  output logic [DATA_W-1:0] data_out,
  output logic              ninth_out,
  output logic              stop_out
);
  import urx_pkg::*;

  localparam int OSR   = 1 << CNT_W;
  localparam int IDX_W = $clog2(DATA_W + 3);
  localparam logic [CNT_W-1:0] VOTE_PT = CNT_W'(OSR / 2 + 1);
  localparam logic [CNT_W-1:0] LAST_PT = CNT_W'(OSR - 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              ninth_q, ninth_d;
  logic [IDX_W-1:0]  stop_idx;

  assign stop_idx = nine_bit ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    idx_d      = idx_q;
    shift_d    = shift_q;
    ninth_d    = ninth_q;
    frame_done = 1'b0;
    case (state_q)
      RX_IDLE: begin
        if (enable && fall) begin
          state_d = RX_ACTIVE;
          cnt_d   = '0;
          idx_d   = '0;
        end
      end
      RX_ACTIVE: begin
        if (tick) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_PT) idx_d = idx_q + 1'b1;
        end
        if (tick && cnt_q == VOTE_PT) begin
          if (idx_q == '0) begin
            if (vote) state_d = RX_IDLE;
          end else if (idx_q == stop_idx) begin
            frame_done = 1'b1;
            state_d    = RX_IDLE;
          end else if (idx_q <= IDX_W'(DATA_W)) begin
            shift_d = {vote, shift_q[DATA_W-1:1]};
          end else begin
            ninth_d = vote;
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
    if (!enable) state_d = RX_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      ninth_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shift_q <= shift_d;
      ninth_q <= ninth_d;
    end
  end

  assign cnt       = cnt_q;
  assign data_out  = shift_q;
  assign ninth_out = ninth_q;
  assign stop_out  = vote;

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> state_q == RX_IDLE);

  // R2
  realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_IDLE && enable && fall) |=> (state_q == RX_ACTIVE && cnt_q == '0));
endmodule

// File: rtl/urx_regs.sv
module urx_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] data_in,
  input  logic              ninth_in,
  input  logic              stop_in,
  input  logic              nine_bit,
  input  logic              addr_filt,
  input  logic              flag_clr,
  input  logic              fe_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_flag,
  output logic              fe
);
  logic [DATA_W-1:0] data_q, data_d;
  logic              bit9_q, bit9_d;
  logic              flag_q, flag_d;
  logic              fe_q, fe_d;
  logic              extra, accept;

  always_comb begin
    extra  = nine_bit ? ninth_in : stop_in;
    accept = frame_done && !flag_q && (!addr_filt || extra);
    data_d = accept ? data_in : data_q;
    bit9_d = accept ? extra : bit9_q;
    flag_d = accept ? 1'b1 : (flag_clr ? 1'b0 : flag_q);
    fe_d   = (frame_done && !stop_in) ? 1'b1 : (fe_clr ? 1'b0 : fe_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      bit9_q <= 1'b0;
      flag_q <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      bit9_q <= bit9_d;
      flag_q <= flag_d;
      fe_q   <= fe_d;
    end
  end

  assign rx_data = data_q;
  assign rx_bit9 = bit9_q;
  assign rx_flag = flag_q;
  assign fe      = fe_q;

  // R5
  no_load_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> ($stable(data_q) && $stable(bit9_q)));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  // R9
  fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_q && !fe_clr) |=> fe_q);
endmodule

// File: rtl/uart_rx_mpf.sv
module uart_rx_mpf #(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic [1:0]        mode,
  input  logic              addr_filt,
  input  logic              fe_alias_sel,
  input  logic              flag_clr,
  input  logic              fe_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_flag,
  output logic              ctl_bit7
);
  localparam int S_FIRST = (1 << CNT_W) / 2 - 1;

  logic             rxd_s, fall, vote, enable, nine_bit;
  logic [CNT_W-1:0] cnt;
  logic             frame_done, ninth, stop_bit, fe;
  logic [DATA_W-1:0] frame_data;

  assign enable   = rx_en && (mode != 2'b00);
  assign nine_bit = mode[1];

  urx_sampler #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W), .S_FIRST(S_FIRST)) u_smp (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(tick16), .cnt(cnt),
    .rxd_s(rxd_s), .fall(fall), .vote(vote)
  );

  urx_framer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .fall(fall), .vote(vote),
    .enable(enable), .nine_bit(nine_bit), .cnt(cnt), .frame_done(frame_done),
    .data_out(frame_data), .ninth_out(ninth), .stop_out(stop_bit)
  );

  urx_regs #(.DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .data_in(frame_data),
    .ninth_in(ninth), .stop_in(stop_bit), .nine_bit(nine_bit),
    .addr_filt(addr_filt), .flag_clr(flag_clr), .fe_clr(fe_clr),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_flag(rx_flag), .fe(fe)
  );

  assign ctl_bit7 = fe_alias_sel ? fe : mode[1];

  // R10
  alias_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fe_alias_sel |-> (ctl_bit7 == mode[1]));

  // R1
  no_frame_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rx_flag && !flag_clr && $past(!rx_en)) |=> !rx_flag);
endmodule

// File: tb/sim_uart_rx_mpf.sv
module sim_uart_rx_mpf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic       rx_en = 1'b1;
  logic [1:0] mode = 2'b01;
  logic       addr_filt = 1'b0;
  logic       fe_alias_sel = 1'b0;
  logic       flag_clr = 1'b0;
  logic       fe_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_flag, ctl_bit7;

  int checks = 0;
  int fails  = 0;
  logic [1:0] tdiv = 2'd0;

  uart_rx_mpf u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
    .mode(mode), .addr_filt(addr_filt), .fe_alias_sel(fe_alias_sel),
    .flag_clr(flag_clr), .fe_clr(fe_clr), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rx_flag(rx_flag), .ctl_bit7(ctl_bit7)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  typedef struct packed {
    logic [1:0] md;
    logic       sm2;
    logic       keep;
    logic [7:0] d;
    logic       b9;
    logic       st;
    logic       ef;
    logic [7:0] ed;
    logic       erb;
    logic       efe;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'b01, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b0},
    '{2'b01, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b0},
    '{2'b10, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b1, 1'b1, 8'h5A, 1'b0, 1'b0},
    '{2'b11, 1'b1, 1'b0, 8'h77, 1'b0, 1'b1, 1'b0, 8'h5A, 1'b0, 1'b0},
    '{2'b11, 1'b1, 1'b0, 8'h81, 1'b1, 1'b1, 1'b1, 8'h81, 1'b1, 1'b0},
    '{2'b01, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h81, 1'b1, 1'b1},
    '{2'b01, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1},
    '{2'b10, 1'b1, 1'b0, 8'hC3, 1'b1, 1'b0, 1'b1, 8'hC3, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (tick16 !== 1'b1) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic pulse(input int which);
    if (which == 0) flag_clr = 1'b1; else fe_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    fe_clr   = 1'b0;
  endtask

  task automatic drive_bit(input logic v, input logic glitch);
    rxd = v;
    if (glitch) begin
      wait_ticks(8);
      rxd = ~v;
      wait_ticks(1);
      rxd = v;
      wait_ticks(7);
    end else begin
      wait_ticks(16);
    end
  endtask

  task automatic send_frame(input logic nine, input logic [7:0] d, input logic b9,
                            input logic st, input int glitch_bit,
                            output logic early, output logic mid);
    drive_bit(1'b0, glitch_bit == 0);
    for (int i = 0; i < 8; i++) drive_bit(d[i], glitch_bit == i + 1);
    if (nine) drive_bit(b9, glitch_bit == 9);
    rxd = st;
    wait_ticks(4);
    early = rx_flag;
    wait_ticks(8);
    mid = rx_flag;
    wait_ticks(4);
    rxd = 1'b1;
    wait_ticks(20);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic e, m;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state
    fe_alias_sel = 1'b1;
    chk("reset R8 flag", {7'd0, rx_flag}, 8'h00);
    chk("reset R7 data", rx_data, 8'h00);
    chk("reset R7 bit9", {7'd0, rx_bit9}, 8'h00);
    chk("reset R9 fe", {7'd0, ctl_bit7}, 8'h00);
    fe_alias_sel = 1'b0;
    wait_ticks(2);

    // Vector table
    for (int i = 0; i < 8; i++) begin
      mode      = VECS[i].md;
      addr_filt = VECS[i].sm2;
      pulse(1);
      if (!VECS[i].keep) pulse(0);
      wait_ticks(1);
      send_frame(VECS[i].md[1], VECS[i].d, VECS[i].b9, VECS[i].st, -1, e, m);
      chk("vec R5/R6/R8 flag", {7'd0, rx_flag}, {7'd0, VECS[i].ef});
      chk("vec R5/R7 data", rx_data, VECS[i].ed);
      chk("vec R6/R7 bit9", {7'd0, rx_bit9}, {7'd0, VECS[i].erb});
      fe_alias_sel = 1'b1;
      @(negedge clk);
      chk("vec R9/R10 fe alias", {7'd0, ctl_bit7}, {7'd0, VECS[i].efe});
      fe_alias_sel = 1'b0;
      @(negedge clk);
      chk("vec R10 mode alias", {7'd0, ctl_bit7}, {7'd0, VECS[i].md[1]});
    end

    // R8: flag timing within the stop bit, then clear
    mode = 2'b01; addr_filt = 1'b0;
    pulse(0); pulse(1);
    send_frame(1'b0, 8'h96, 1'b0, 1'b1, -1, e, m);
    chk("R8 flag before stop vote", {7'd0, e}, 8'h00);
    chk("R8 flag after stop vote", {7'd0, m}, 8'h01);
    chk("R7 data 96", rx_data, 8'h96);
    pulse(0);
    chk("R8 flag cleared", {7'd0, rx_flag}, 8'h00);

    // R3: single disturbed sample in a data bit and in the start bit
    send_frame(1'b0, 8'h69, 1'b0, 1'b1, 3, e, m);
    chk("R3 glitch data bit", rx_data, 8'h69);
    pulse(0);
    send_frame(1'b0, 8'h4B, 1'b0, 1'b1, 0, e, m);
    chk("R3 glitch start bit", rx_data, 8'h4B);
    chk("R3 glitch start flag", {7'd0, rx_flag}, 8'h01);
    pulse(0);

    // R4: short low pulse is a false start
    rxd = 1'b0;
    wait_ticks(7);
    rxd = 1'b1;
    wait_ticks(200);
    chk("R4 false start flag", {7'd0, rx_flag}, 8'h00);
    chk("R4 false start data", rx_data, 8'h4B);
    send_frame(1'b0, 8'hE1, 1'b0, 1'b1, -1, e, m);
    chk("R4 frame after false start", rx_data, 8'hE1);
    pulse(0);

    // R2: start edge off the tick grid
    @(negedge clk);
    @(negedge clk);
    send_frame(1'b0, 8'h2D, 1'b0, 1'b1, -1, e, m);
    chk("R2 offset edge data", rx_data, 8'h2D);
    chk("R2 offset edge flag", {7'd0, rx_flag}, 8'h01);
    pulse(0);

    // R1: receiver disabled, then mode 00
    rx_en = 1'b0;
    send_frame(1'b0, 8'h55, 1'b0, 1'b1, -1, e, m);
    chk("R1 disabled flag", {7'd0, rx_flag}, 8'h00);
    chk("R1 disabled data", rx_data, 8'h2D);
    rx_en = 1'b1;
    mode = 2'b00;
    send_frame(1'b0, 8'hAA, 1'b0, 1'b1, -1, e, m);
    chk("R1 mode 00 flag", {7'd0, rx_flag}, 8'h00);
    chk("R1 mode 00 data", rx_data, 8'h2D);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule